// File: doc/BRIEF.md
# Posted Write Buffer with Store Gathering

This block sits between a fast processor bus and a slower master port. It accepts processor writes aimed at memory space or I/O space and posts them: the processor write is acknowledged as soon as its data is latched. The processor bus is then free while the drain side moves the data out at its own pace. Storage is two half-line slots of 16 bytes each. Each slot holds an address, a per-byte valid mask and a burst flag. A processor burst of four 8-byte beats joins both slots into one 32-byte line. A stream of single-beat writes uses the two slots independently, and writes can be merged (gathered) into the slot that is not yet scheduled to drain.

The drain side uses a request/grant handshake. A request presents one 16-byte half with its 16-byte-aligned address, its byte enables (the slot's valid mask) and its data, and one grant retires it. A head pointer always names the oldest occupied slot, and that slot is the one presented. A synchronizing request from the processor stops further merging and is acknowledged only once nothing is left posted.

Each slot has its own state machine. SL_EMPTY moves to SL_OPEN when a memory-space write lands in a slot that is not the head while gathering is enabled. SL_EMPTY moves to SL_SEALED when the write is an I/O-space write, when gathering is disabled, when the slot becomes head in that same cycle, or when the write is a burst. SL_OPEN moves to SL_SEALED when the slot becomes head or when a synchronizing request is seen. SL_SEALED moves to SL_EMPTY when its drain is granted. The write-side state machine has two states. WR_IDLE moves to WR_BURST when the first beat of a burst is accepted. WR_BURST returns to WR_IDLE when the fourth beat is accepted.

Top module: `pw_gather_buf`

## Requirements
- R1: After reset both slots are empty: `dr_req` is 0 and `sync_ack` is 0 while `cpu_sync` is low.
- R2: A single-beat write into an empty buffer is acknowledged in the cycle it is requested, and `dr_req` is high from the next cycle. `dr_addr` is the write address with bits [3:0] cleared. Byte enable bit b of the write appears at `dr_be` bit 8*addr[3]+b, and data byte b appears at byte 8*addr[3]+b of `dr_data`.
- R3: A second single-beat write, made while the first is still waiting, goes into the other slot even when it hits the same 16-byte half line. It drains as a separate transfer.
- R4: With `gather_en`=1, a memory-space single-beat write whose address bits [31:4] equal those of the non-head slot, while that slot is open, is accepted without a new slot. Its enabled bytes overwrite that slot's bytes, and its enables are ORed into the slot's mask.
- R5: With `gather_en`=0 no write is merged. A write that finds both slots occupied is held with `cpu_ack`=0.
- R6: A write with `cpu_io`=1 is posted but never merged. No later write is merged into a slot that holds an I/O write.
- R7: A write whose address bits [31:4] differ from the non-head slot's is not merged.
- R8: Slots drain in the order they were filled. While `dr_req` is high and `dr_gnt` is low, `dr_req`, `dr_addr`, `dr_be` and `dr_data` hold steady.
- R9: Once a slot becomes head (is scheduled to drain), no later write is merged into it. A write to the same half line goes into the freed slot.
- R10: `cpu_sync` high closes the open slot to further merging. `sync_ack` is high only while `cpu_sync` is high and both slots are empty.
- R11: A burst (`cpu_burst`=1) is held until both slots are empty. It then takes four 8-byte beats, with `cpu_be` ignored and address bits [4:0] ignored. `dr_req` stays low until the last beat. The line then drains as two transfers: first at the line address with beats 0 and 1, then at line address + 16 with beats 2 and 3. Both transfers have `dr_be` all ones and `dr_burst`=1, and `dr_last` is high only on the second.
- R12: A held single-beat write is acknowledged in the first cycle after a grant frees a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gather_en | input | 1 | Allows merging of memory-space writes |
| cpu_req | input | 1 | Processor write request |
| cpu_burst | input | 1 | Request is a beat of a four-beat line burst |
| cpu_io | input | 1 | Write targets I/O space |
| cpu_addr | input | 32 | Byte address of the write |
| cpu_be | input | 8 | Byte enables of the 8-byte beat |
| cpu_data | input | 64 | Beat data |
| cpu_ack | output | 1 | Write accepted this cycle |
| cpu_sync | input | 1 | Synchronizing request |
| sync_ack | output | 1 | All posted writes have drained |
| dr_req | output | 1 | A half line is ready to drain |
| dr_gnt | input | 1 | Drain side takes the presented half line |
| dr_addr | output | 32 | 16-byte-aligned address of the half line |
| dr_be | output | 16 | Byte enables (valid mask) |
| dr_data | output | 128 | Half-line data |
| dr_burst | output | 1 | Half belongs to a line burst |
| dr_last | output | 1 | Last transfer of this write |

## Verification
The assertions check on every cycle that the head slot is never open to merging, that an empty head implies an empty partner, and that a sealed slot stays sealed until it is granted. They also check that a held drain request keeps its address, enables and data, that a burst half always shows full enables, and that `sync_ack` never rises while data is still posted. Only the directed scenarios can show what the data and masks look like after merging, the exact order and content of the drained transfers, that a write to the same half line still lands in the second slot, and the cycles in which held writes and bursts are finally acknowledged.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [1:0] {
        SL_EMPTY  = 2'd0,
        SL_OPEN   = 2'd1,
        SL_SEALED = 2'd2
    } slot_st_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_BURST = 1'b1
    } wr_st_e;

endpackage

// File: rtl/pwb_slot.sv
module pwb_slot
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned BEAT_BYTES = 8,
    parameter int unsigned HALF_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic                      wr_new_i,
    input  logic                      wr_seal_i,
    input  logic                      wr_burst_i,
    input  logic [ADDR_W-1:0]         wr_addr_i,
    input  logic [LANE_W-1:0]         wr_lane_i,
    input  logic [BEAT_BYTES-1:0]     wr_be_i,
    input  logic [BEAT_BYTES*8-1:0]   wr_data_i,
    input  logic                      seal_i,
    input  logic                      clear_i,
    output slot_st_e                  st_o,
    output logic [ADDR_W-1:0]         addr_o,
    output logic [HALF_BYTES-1:0]     mask_o,
    output logic [HALF_BYTES*8-1:0]   data_o,
    output logic                      burst_o
);
    localparam int unsigned LANES  = HALF_BYTES / BEAT_BYTES;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned OFF_W  = $clog2(HALF_BYTES);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((1 << OFF_W) - 1);

    slot_st_e                st_q, st_d;
    logic [ADDR_W-1:0]       addr_q, addr_d;
    logic [HALF_BYTES-1:0]   mask_q, mask_d;
    logic [HALF_BYTES*8-1:0] data_q, data_d;
    logic                    burst_q, burst_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= SL_EMPTY;
            addr_q  <= '0;
            mask_q  <= '0;
            data_q  <= '0;
            burst_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            addr_q  <= addr_d;
            mask_q  <= mask_d;
            data_q  <= data_d;
            burst_q <= burst_d;
        end
    end

    always_comb begin
        st_d    = st_q;
        addr_d  = addr_q;
        mask_d  = mask_q;
        data_d  = data_q;
        burst_d = burst_q;
        if (clear_i) begin
            st_d    = SL_EMPTY;
            mask_d  = '0;
            burst_d = 1'b0;
        end
        if (wr_en_i) begin
            if (wr_new_i) begin
                mask_d  = '0;
                addr_d  = wr_addr_i & ~OFF_MASK;
                burst_d = wr_burst_i;
                st_d    = wr_seal_i ? SL_SEALED : SL_OPEN;
            end
            for (int l = 0; l < LANES; l++) begin
                for (int b = 0; b < BEAT_BYTES; b++) begin
                    if (wr_lane_i == LANE_W'(l) && wr_be_i[b]) begin
                        data_d[(l*BEAT_BYTES+b)*8 +: 8] = wr_data_i[b*8 +: 8];
                        mask_d[l*BEAT_BYTES+b]          = 1'b1;
                    end
                end
            end
        end
        if (seal_i && st_d == SL_OPEN) begin
            st_d = SL_SEALED;
        end
    end

    assign st_o    = st_q;
    assign addr_o  = addr_q;
    assign mask_o  = mask_q;
    assign data_o  = data_q;
    assign burst_o = burst_q;

    AST_MERGE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_new_i) |-> (st_q != SL_EMPTY)); // R4
    AST_NO_CLEAR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(clear_i && wr_en_i)); // R8
    AST_SEAL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_SEALED && !clear_i) |=> (st_q == SL_SEALED)); // R9
    AST_OPEN_NOT_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SL_OPEN) |-> !burst_q); // R11

endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned BEAT_BYTES = 8,
    parameter int unsigned HALF_BYTES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gather_en,
    input  logic                  cpu_req,
    input  logic                  cpu_burst,
    input  logic                  cpu_io,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [BEAT_BYTES-1:0] cpu_be,
    input  logic                  cpu_sync,
    output logic                  cpu_ack,
    output logic                  sync_ack,
    input  slot_st_e              st_i [2],
    input  logic [ADDR_W-1:0]     slot_addr_i [2],
    input  logic                  dr_gnt,
    output logic                  dr_req,
    output logic                  head_o,
    output logic [1:0]            wr_en_o,
    output logic                  wr_new_o,
    output logic                  wr_seal_o,
    output logic                  wr_burst_o,
    output logic [ADDR_W-1:0]     wr_addr_o,
    output logic [LANE_W-1:0]     wr_lane_o,
    output logic [BEAT_BYTES-1:0] wr_be_o,
    output logic [1:0]            seal_o,
    output logic [1:0]            clear_o
);
    localparam int unsigned LANES       = HALF_BYTES / BEAT_BYTES;
    localparam int unsigned LANE_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned OFF_W       = $clog2(HALF_BYTES);
    localparam int unsigned BEAT_OFF    = $clog2(BEAT_BYTES);
    localparam int unsigned BURST_BEATS = 2 * LANES;
    localparam int unsigned BEAT_CNT_W  = LANE_W + 1;
    localparam logic [ADDR_W-1:0] LINE_MASK = ADDR_W'((1 << (OFF_W + 1)) - 1);
    localparam logic [ADDR_W-1:0] HALF_BIT  = ADDR_W'(1) << OFF_W;

    wr_st_e                wr_q, wr_d;
    logic [BEAT_CNT_W-1:0] beat_q, beat_d;
    logic                  head_q, head_d;
    logic                  tail;
    logic                  both_empty;
    logic                  gnt_fire;
    logic                  hit;
    logic                  wr_en;
    logic                  tgt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= WR_IDLE;
            beat_q <= '0;
            head_q <= 1'b0;
        end else begin
            wr_q   <= wr_d;
            beat_q <= beat_d;
            head_q <= head_d;
        end
    end

    assign tail       = ~head_q;
    assign both_empty = (st_i[0] == SL_EMPTY) && (st_i[1] == SL_EMPTY);
    assign hit        = (st_i[tail] == SL_OPEN) && gather_en && !cpu_io &&
                        (cpu_addr[ADDR_W-1:OFF_W] == slot_addr_i[tail][ADDR_W-1:OFF_W]);

    always_comb begin
        dr_req     = (st_i[head_q] != SL_EMPTY) && (wr_q == WR_IDLE);
        gnt_fire   = dr_req && dr_gnt;
        sync_ack   = cpu_sync && both_empty;
        cpu_ack    = 1'b0;
        wr_en      = 1'b0;
        wr_new_o   = 1'b0;
        wr_seal_o  = 1'b1;
        wr_burst_o = 1'b0;
        wr_addr_o  = cpu_addr;
        wr_lane_o  = cpu_addr[BEAT_OFF +: LANE_W];
        wr_be_o    = cpu_be;
        tgt        = head_q;
        wr_d       = wr_q;
        beat_d     = beat_q;
        unique case (wr_q)
            WR_IDLE: begin
                if (cpu_req && !cpu_sync) begin
                    if (cpu_burst) begin
                        if (both_empty) begin
                            cpu_ack    = 1'b1;
                            wr_en      = 1'b1;
                            wr_new_o   = 1'b1;
                            wr_burst_o = 1'b1;
                            wr_addr_o  = cpu_addr & ~LINE_MASK;
                            wr_lane_o  = '0;
                            wr_be_o    = '1;
                            wr_d       = WR_BURST;
                            beat_d     = BEAT_CNT_W'(1);
                        end
                    end else if (hit) begin
                        cpu_ack = 1'b1;
                        wr_en   = 1'b1;
                        tgt     = tail;
                    end else if (both_empty) begin
                        cpu_ack  = 1'b1;
                        wr_en    = 1'b1;
                        wr_new_o = 1'b1;
                    end else if (st_i[tail] == SL_EMPTY) begin
                        cpu_ack   = 1'b1;
                        wr_en     = 1'b1;
                        wr_new_o  = 1'b1;
                        tgt       = tail;
                        wr_seal_o = cpu_io || !gather_en || gnt_fire;
                    end
                end
            end
            WR_BURST: begin
                if (cpu_req) begin
                    cpu_ack    = 1'b1;
                    wr_en      = 1'b1;
                    wr_burst_o = 1'b1;
                    wr_be_o    = '1;
                    wr_lane_o  = beat_q[LANE_W-1:0];
                    wr_addr_o  = slot_addr_i[head_q] | HALF_BIT;
                    tgt        = beat_q[LANE_W] ? tail : head_q;
                    wr_new_o   = (beat_q[LANE_W-1:0] == '0);
                    if (beat_q == BEAT_CNT_W'(BURST_BEATS - 1)) begin
                        wr_d   = WR_IDLE;
                        beat_d = '0;
                    end else begin
                        beat_d = beat_q + BEAT_CNT_W'(1);
                    end
                end
            end
        endcase
        head_d = gnt_fire ? tail : head_q;
    end

    always_comb begin
        for (int i = 0; i < 2; i++) begin
            wr_en_o[i] = wr_en && (tgt == 1'(i));
            seal_o[i]  = cpu_sync || (gnt_fire && (tail == 1'(i)));
            clear_o[i] = gnt_fire && (head_q == 1'(i));
        end
    end

    assign head_o = head_q;

    AST_HEAD_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        (st_i[head_q] == SL_EMPTY) |-> (st_i[tail] == SL_EMPTY)); // R8
    AST_HEAD_NEVER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_i[head_q] != SL_OPEN); // R9
    AST_BURST_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_q == WR_IDLE && cpu_ack && cpu_burst) |-> both_empty); // R11
    AST_SYNC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ack |-> (st_i[0] == SL_EMPTY && st_i[1] == SL_EMPTY)); // R10
    AST_NO_IO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_io && wr_q == WR_IDLE) |-> wr_new_o); // R6

endmodule

// File: rtl/pw_gather_buf.sv
module pw_gather_buf
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned BEAT_BYTES = 8,
    parameter int unsigned HALF_BYTES = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gather_en,
    input  logic                    cpu_req,
    input  logic                    cpu_burst,
    input  logic                    cpu_io,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [BEAT_BYTES-1:0]   cpu_be,
    input  logic [BEAT_BYTES*8-1:0] cpu_data,
    output logic                    cpu_ack,
    input  logic                    cpu_sync,
    output logic                    sync_ack,
    output logic                    dr_req,
    input  logic                    dr_gnt,
    output logic [ADDR_W-1:0]       dr_addr,
    output logic [HALF_BYTES-1:0]   dr_be,
    output logic [HALF_BYTES*8-1:0] dr_data,
    output logic                    dr_burst,
    output logic                    dr_last
);
    localparam int unsigned LANES  = HALF_BYTES / BEAT_BYTES;
    localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int unsigned OFF_W  = $clog2(HALF_BYTES);

    slot_st_e                st     [2];
    logic [ADDR_W-1:0]       s_addr [2];
    logic [HALF_BYTES-1:0]   s_mask [2];
    logic [HALF_BYTES*8-1:0] s_data [2];
    logic [1:0]              s_burst;
    logic                    head;
    logic [1:0]              wr_en, seal, clear;
    logic                    wr_new, wr_seal, wr_burst;
    logic [ADDR_W-1:0]       wr_addr;
    logic [LANE_W-1:0]       wr_lane;
    logic [BEAT_BYTES-1:0]   wr_be;

    pwb_ctrl #(
        .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .HALF_BYTES(HALF_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .gather_en(gather_en),
        .cpu_req(cpu_req), .cpu_burst(cpu_burst), .cpu_io(cpu_io),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_sync(cpu_sync),
        .cpu_ack(cpu_ack), .sync_ack(sync_ack),
        .st_i(st), .slot_addr_i(s_addr), .dr_gnt(dr_gnt), .dr_req(dr_req),
        .head_o(head), .wr_en_o(wr_en), .wr_new_o(wr_new), .wr_seal_o(wr_seal),
        .wr_burst_o(wr_burst), .wr_addr_o(wr_addr), .wr_lane_o(wr_lane),
        .wr_be_o(wr_be), .seal_o(seal), .clear_o(clear)
    );

    for (genvar i = 0; i < 2; i++) begin : g_slot
        pwb_slot #(
            .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES), .HALF_BYTES(HALF_BYTES)
        ) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en_i(wr_en[i]), .wr_new_i(wr_new), .wr_seal_i(wr_seal),
            .wr_burst_i(wr_burst), .wr_addr_i(wr_addr), .wr_lane_i(wr_lane),
            .wr_be_i(wr_be), .wr_data_i(cpu_data),
            .seal_i(seal[i]), .clear_i(clear[i]),
            .st_o(st[i]), .addr_o(s_addr[i]), .mask_o(s_mask[i]),
            .data_o(s_data[i]), .burst_o(s_burst[i])
        );
    end

    assign dr_addr  = s_addr[head];
    assign dr_be    = s_mask[head];
    assign dr_data  = s_data[head];
    assign dr_burst = s_burst[head];
    assign dr_last  = !s_burst[head] || s_addr[head][OFF_W];

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_req && !dr_gnt) |=> (dr_req && $stable(dr_addr) && $stable(dr_be) && $stable(dr_data))); // R8
    AST_BURST_FULL_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_req && dr_burst) |-> (dr_be == '1)); // R11

endmodule

// File: tb/test_pw_gather_buf.sv
module test_pw_gather_buf;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gather_en = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_burst = 1'b0;
    logic         cpu_io = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic [7:0]   cpu_be = '0;
    logic [63:0]  cpu_data = '0;
    logic         cpu_ack;
    logic         cpu_sync = 1'b0;
    logic         sync_ack;
    logic         dr_req;
    logic         dr_gnt = 1'b0;
    logic [31:0]  dr_addr;
    logic [15:0]  dr_be;
    logic [127:0] dr_data;
    logic         dr_burst;
    logic         dr_last;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pw_gather_buf i_pw_gather_buf (
        .clk(clk), .rst_n(rst_n), .gather_en(gather_en),
        .cpu_req(cpu_req), .cpu_burst(cpu_burst), .cpu_io(cpu_io),
        .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_data(cpu_data),
        .cpu_ack(cpu_ack), .cpu_sync(cpu_sync), .sync_ack(sync_ack),
        .dr_req(dr_req), .dr_gnt(dr_gnt), .dr_addr(dr_addr), .dr_be(dr_be),
        .dr_data(dr_data), .dr_burst(dr_burst), .dr_last(dr_last)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] byte_bits(input logic [15:0] m);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    task automatic put(inout logic [127:0] d, inout logic [15:0] m,
                       input logic [31:0] a, input logic [7:0] be, input logic [63:0] wd);
        for (int b = 0; b < 8; b++) begin
            if (be[b]) begin
                d[(int'(a[3])*8 + b)*8 +: 8] = wd[b*8 +: 8];
                m[int'(a[3])*8 + b] = 1'b1;
            end
        end
    endtask

    task automatic cpu_write(input logic [31:0] a, input logic [7:0] be, input logic [63:0] d,
                             input logic io, input int maxw, output bit acked);
        @(negedge clk);
        cpu_req = 1'b1; cpu_burst = 1'b0; cpu_io = io;
        cpu_addr = a; cpu_be = be; cpu_data = d;
        acked = 1'b0;
        for (int w = 0; w <= maxw && !acked; w++) begin
            #1;
            if (cpu_ack) begin
                acked = 1'b1;
                @(posedge clk);
            end else if (w < maxw) begin
                @(negedge clk);
            end
        end
        #1 cpu_req = 1'b0; cpu_io = 1'b0;
    endtask

    task automatic drain(input string tag, input logic [31:0] a, input logic [15:0] be,
                         input logic [127:0] d, input logic bu, input logic la);
        @(negedge clk);
        for (int w = 0; w < 20 && !dr_req; w++) @(negedge clk);
        #1;
        chk({tag, " dr_req"}, dr_req, 1'b1);
        chk({tag, " dr_addr"}, dr_addr, a);
        chk({tag, " dr_be"}, dr_be, be);
        chk({tag, " dr_data"}, dr_data & byte_bits(be), d & byte_bits(be));
        chk({tag, " dr_burst"}, dr_burst, bu);
        chk({tag, " dr_last"}, dr_last, la);
        dr_gnt = 1'b1;
        @(posedge clk);
        #1 dr_gnt = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 dr_req after reset", dr_req, 1'b0);
        chk("R1 sync_ack after reset", sync_ack, 1'b0);
        chk("R1 cpu_ack idle", cpu_ack, 1'b0);
    endtask

    task automatic t_separate();
        bit ok;
        logic [127:0] d0 = '0, d1 = '0;
        logic [15:0]  m0 = '0, m1 = '0;
        gather_en = 1'b1;
        put(d0, m0, 32'h1000_0108, 8'h0F, 64'hA1A2A3A4_A5A6A7A8);
        put(d1, m1, 32'h1000_0100, 8'hFF, 64'hB1B2B3B4_B5B6B7B8);
        cpu_write(32'h1000_0108, 8'h0F, 64'hA1A2A3A4_A5A6A7A8, 1'b0, 0, ok);
        chk("R2 single write acked at once", ok, 1'b1);
        @(negedge clk); #1;
        chk("R2 dr_req raised", dr_req, 1'b1);
        chk("R2 aligned address", dr_addr, 32'h1000_0100);
        chk("R2 upper lane enables", dr_be, 16'h0F00);
        cpu_write(32'h1000_0100, 8'hFF, 64'hB1B2B3B4_B5B6B7B8, 1'b0, 0, ok);
        chk("R3 second write takes other slot", ok, 1'b1);
        repeat (3) @(negedge clk);
        #1 chk("R8 request held without grant", dr_be, 16'h0F00);
        drain("R8 first filled drains first", 32'h1000_0100, m0, d0, 1'b0, 1'b1);
        drain("R3 second write separate", 32'h1000_0100, m1, d1, 1'b0, 1'b1);
        @(negedge clk); #1 chk("R8 idle after drains", dr_req, 1'b0);
    endtask

    task automatic t_gather();
        bit ok;
        logic [127:0] d0 = '0, d1 = '0;
        logic [15:0]  m0 = '0, m1 = '0;
        gather_en = 1'b1;
        put(d0, m0, 32'h2000_0100, 8'h0F, 64'h11111111_22222222);
        put(d1, m1, 32'h2000_0108, 8'h01, 64'h00000000_000000C1);
        put(d1, m1, 32'h2000_0100, 8'hF0, 64'hD1D2D3D4_00000000);
        put(d1, m1, 32'h2000_0108, 8'h03, 64'h00000000_0000E2E1);
        cpu_write(32'h2000_0100, 8'h0F, 64'h11111111_22222222, 1'b0, 0, ok);
        cpu_write(32'h2000_0108, 8'h01, 64'h00000000_000000C1, 1'b0, 0, ok);
        cpu_write(32'h2000_0100, 8'hF0, 64'hD1D2D3D4_00000000, 1'b0, 0, ok);
        chk("R4 merge accepted while full", ok, 1'b1);
        cpu_write(32'h2000_0108, 8'h03, 64'h00000000_0000E2E1, 1'b0, 0, ok);
        chk("R4 overlapping merge accepted", ok, 1'b1);
        drain("R4 first slot untouched", 32'h2000_0100, m0, d0, 1'b0, 1'b1);
        drain("R4 gathered slot", 32'h2000_0100, m1, d1, 1'b0, 1'b1);
    endtask

    task automatic t_nogather();
        bit ok;
        gather_en = 1'b0;
        cpu_write(32'h3000_0000, 8'h01, 64'h55, 1'b0, 0, ok);
        cpu_write(32'h3000_0000, 8'h02, 64'h6600, 1'b0, 0, ok);
        cpu_write(32'h3000_0000, 8'h04, 64'h770000, 1'b0, 4, ok);
        chk("R5 no merge when disabled", ok, 1'b0);
        drain("R5 drain first", 32'h3000_0000, 16'h0001, 128'h55, 1'b0, 1'b1);
        cpu_write(32'h3000_0000, 8'h04, 64'h770000, 1'b0, 0, ok);
        chk("R12 held write accepted after grant", ok, 1'b1);
        drain("R5 second unmerged", 32'h3000_0000, 16'h0002, 128'h6600, 1'b0, 1'b1);
        drain("R5 third unmerged", 32'h3000_0000, 16'h0004, 128'h770000, 1'b0, 1'b1);
        gather_en = 1'b1;
    endtask

    task automatic t_io();
        bit ok;
        cpu_write(32'h3100_0000, 8'h01, 64'h01, 1'b0, 0, ok);
        cpu_write(32'h3100_0010, 8'h01, 64'h02, 1'b1, 0, ok);
        cpu_write(32'h3100_0018, 8'h01, 64'h03, 1'b1, 3, ok);
        chk("R6 io write not merged", ok, 1'b0);
        cpu_write(32'h3100_0018, 8'h01, 64'h03, 1'b0, 3, ok);
        chk("R6 no merge into io slot", ok, 1'b0);
        drain("R6 mem drain", 32'h3100_0000, 16'h0001, 128'h01, 1'b0, 1'b1);
        drain("R6 io drain", 32'h3100_0010, 16'h0001, 128'h02, 1'b0, 1'b1);
    endtask

    task automatic t_otherhalf();
        bit ok;
        cpu_write(32'h4000_0000, 8'h01, 64'h0A, 1'b0, 0, ok);
        cpu_write(32'h4000_0010, 8'h01, 64'h0B, 1'b0, 0, ok);
        cpu_write(32'h4000_0000, 8'h02, 64'h0C00, 1'b0, 4, ok);
        chk("R7 other half line not merged", ok, 1'b0);
        chk("R12 held while full", cpu_ack, 1'b0);
        drain("R7 first", 32'h4000_0000, 16'h0001, 128'h0A, 1'b0, 1'b1);
        cpu_write(32'h4000_0000, 8'h02, 64'h0C00, 1'b0, 0, ok);
        chk("R12 accepted right after grant", ok, 1'b1);
        drain("R7 second", 32'h4000_0010, 16'h0001, 128'h0B, 1'b0, 1'b1);
        drain("R7 third", 32'h4000_0000, 16'h0002, 128'h0C00, 1'b0, 1'b1);
    endtask

    task automatic t_schedule();
        bit ok;
        cpu_write(32'h7000_0000, 8'h01, 64'h71, 1'b0, 0, ok);
        cpu_write(32'h7000_0010, 8'h01, 64'h72, 1'b0, 0, ok);
        drain("R9 first", 32'h7000_0000, 16'h0001, 128'h71, 1'b0, 1'b1);
        cpu_write(32'h7000_0010, 8'h02, 64'h7300, 1'b0, 0, ok);
        chk("R9 write to scheduled line takes free slot", ok, 1'b1);
        drain("R9 scheduled slot not merged", 32'h7000_0010, 16'h0001, 128'h72, 1'b0, 1'b1);
        drain("R9 new slot", 32'h7000_0010, 16'h0002, 128'h7300, 1'b0, 1'b1);
    endtask

    task automatic t_sync();
        bit ok;
        cpu_write(32'h6000_0000, 8'h01, 64'h61, 1'b0, 0, ok);
        cpu_write(32'h6000_0010, 8'h01, 64'h62, 1'b0, 0, ok);
        @(negedge clk) cpu_sync = 1'b1;
        #1 chk("R10 no sync ack while posted", sync_ack, 1'b0);
        @(negedge clk) cpu_sync = 1'b0;
        cpu_write(32'h6000_0018, 8'h01, 64'h63, 1'b0, 3, ok);
        chk("R10 sync closed gathering", ok, 1'b0);
        @(negedge clk) cpu_sync = 1'b1;
        drain("R10 first", 32'h6000_0000, 16'h0001, 128'h61, 1'b0, 1'b1);
        drain("R10 second", 32'h6000_0010, 16'h0001, 128'h62, 1'b0, 1'b1);
        @(negedge clk); #1 chk("R10 sync ack when empty", sync_ack, 1'b1);
        cpu_sync = 1'b0;
        #1 chk("R10 sync ack drops with request", sync_ack, 1'b0);
    endtask

    task automatic t_burst();
        bit ok;
        logic [63:0] bt [4];
        for (int k = 0; k < 4; k++) bt[k] = {8{8'(8'h80 + k)}};
        cpu_write(32'h5100_0000, 8'h01, 64'h5A, 1'b0, 0, ok);
        @(negedge clk);
        cpu_req = 1'b1; cpu_burst = 1'b1; cpu_addr = 32'h5000_0047;
        cpu_be = 8'h00; cpu_data = bt[0];
        for (int w = 0; w < 3; w++) begin
            #1 chk("R11 burst held while posted", cpu_ack, 1'b0);
            @(negedge clk);
        end
        drain("R11 earlier write", 32'h5100_0000, 16'h0001, 128'h5A, 1'b0, 1'b1);
        @(negedge clk);
        #1 chk("R11 first beat accepted once empty", cpu_ack, 1'b1);
        @(posedge clk);
        for (int k = 1; k < 4; k++) begin
            @(negedge clk) cpu_data = bt[k];
            #1 chk("R11 beat accepted", cpu_ack, 1'b1);
            if (k == 1) chk("R11 no drain during fill", dr_req, 1'b0);
            @(posedge clk);
        end
        #1 cpu_req = 1'b0; cpu_burst = 1'b0;
        drain("R11 first half", 32'h5000_0040, 16'hFFFF, {bt[1], bt[0]}, 1'b1, 1'b0);
        drain("R11 second half", 32'h5000_0050, 16'hFFFF, {bt[3], bt[2]}, 1'b1, 1'b1);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_separate();
        t_gather();
        t_nogather();
        t_io();
        t_otherhalf();
        t_schedule();
        t_sync();
        t_burst();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule